// File: doc/BRIEF.md
# Bulk-OUT Receive Buffer with Live Length

This block is the receive buffer for one bulk OUT endpoint of a USB device controller. It sits between the serial interface engine and the CPU. While an OUT data stage is in progress, the engine delivers bytes one per strobe. The block stores them and shows a live byte count on an 8-bit length output.

When the packet ends, the engine reports whether reception was normal. On a normal end, the block keeps the data and raises a level interrupt. On an abnormal end, it throws the data away: the length drops to zero and no interrupt is raised.

The CPU drains the packet through a single data port. The port always presents the next unread byte. Each read strobe removes one byte and lowers the length by one, so the CPU can read exactly the reported number of bytes. The length is an output only; nothing can write it.

Top module: `bulkOutRxBuf`

## Requirements
- R1: Each accepted engine byte (`sieValid` high, `sieEnd` low) raises `cpuLen` by one from the cycle after it. The first byte after an ended packet starts a new packet and sets `cpuLen` to 1.
- R2: An end of packet with `sieGood` low sets `cpuLen` to 0 and leaves `irq` low.
- R3: An end of packet with `sieGood` high and no overflow keeps the byte count in `cpuLen` and drives `irq` high from the next cycle. No other event raises `irq`.
- R4: Outside reception with `cpuLen` nonzero, `cpuData` shows the oldest unread byte in arrival order. A `cpuRd` strobe removes that byte and lowers `cpuLen` by one.
- R5: With `cpuLen` at 0, `cpuData` reads 0x00, and `cpuRd` changes nothing.
- R6: `cpuLen` saturates at DEPTH. Any further byte in the same packet marks it as overflowed, and an overflowed packet ends as in R2 regardless of `sieGood`.
- R7: Once raised, `irq` stays high until a read takes `cpuLen` from 1 to 0, a `cpuAck` strobe arrives, or the next packet starts.
- R8: An end with no bytes before it is a zero-length packet. If good, it sets `irq` with `cpuLen` at 0.
- R9: `sieValid` is ignored in a cycle where `sieEnd` is high. During reception, `cpuRd` has no effect and `cpuData` reads 0x00.
- R10: After reset, `cpuLen` is 0, `irq` is low and `cpuData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sieValid | input | 1 | Engine byte strobe |
| sieByte | input | 8 | Engine byte |
| sieEnd | input | 1 | End-of-packet strobe |
| sieGood | input | 1 | Reception status with `sieEnd`: 1 normal, 0 abnormal |
| cpuRd | input | 1 | CPU read strobe for the data port |
| cpuAck | input | 1 | CPU interrupt acknowledge strobe |
| cpuData | output | 8 | Data port, next unread byte |
| cpuLen | output | 8 | Remaining byte count, read-only |
| irq | output | 1 | Level interrupt for a good packet |

## Verification
The bench builds the block with DEPTH 16 and an 8-bit length. At that depth, random packet lengths up to DEPTH+4 regularly cross the saturation point, so overflowed packets and packets of exactly DEPTH bytes both occur often. Draining past the end of a packet, partial drains followed by an acknowledge, and new packets arriving while an interrupt is pending all come up in a short run.

// File: rtl/bulk_rx_pkg.sv
package bulk_rx_pkg;
  typedef struct packed {
    logic startPkt;
    logic storeByte;
    logic discard;
    logic popByte;
  } rxStrobe_t;
endpackage

// File: rtl/rxCtrl.sv
module rxCtrl
  import bulk_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sieValid,
  input  logic             sieEnd,
  input  logic             sieGood,
  input  logic             cpuRd,
  input  logic             cpuAck,
  input  logic [LEN_W-1:0] len,
  input  logic             lenZero,
  input  logic             lenFull,
  output rxStrobe_t        strobe,
  output logic             inPkt,
  output logic             irq
);
  logic ovf;
  logic accept;
  logic endGood;
  logic lastPop;

  assign accept  = sieValid & ~sieEnd;
  assign endGood = sieEnd & sieGood & ~(inPkt & ovf);
  assign lastPop = strobe.popByte & (len == LEN_W'(1));

  always_comb begin
    strobe.startPkt  = ~inPkt & (accept | sieEnd);
    strobe.storeByte = accept & (~inPkt | ~lenFull);
    strobe.discard   = sieEnd & ~endGood;
    strobe.popByte   = cpuRd & ~inPkt & ~lenZero & ~strobe.startPkt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt <= 1'b0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (sieEnd) inPkt <= 1'b0;
      else if (accept) inPkt <= 1'b1;

      if (strobe.startPkt) ovf <= 1'b0;
      else if (inPkt && accept && lenFull) ovf <= 1'b1;

      if (endGood) irq <= 1'b1;
      else if (strobe.startPkt || strobe.discard || cpuAck || lastPop) irq <= 1'b0;
    end
  end

  // R2: an abnormal end leaves no interrupt and no length
  a_r2_bad_end_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (sieEnd && !sieGood) |=> (!irq && lenZero));

  // R3: the interrupt rises only after a good end
  a_r3_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(sieEnd && sieGood));

  // R6: an overflowed packet never raises the interrupt
  a_r6_ovf_blocks_irq: assert property (@(posedge clk) disable iff (!rstN)
    (sieEnd && inPkt && ovf) |=> (!irq && lenZero));

  // R7: an acknowledge drops the interrupt
  a_r7_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    (irq && cpuAck && !sieEnd) |=> !irq);
endmodule

// File: rtl/rxData.sv
module rxData
  import bulk_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strobe,
  input  logic [7:0]       inByte,
  input  logic             hold,
  input  logic             cpuRd,
  output logic [LEN_W-1:0] len,
  output logic             lenZero,
  output logic             lenFull,
  output logic [7:0]       dataOut
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] wrIdx;

  assign wrIdx   = strobe.startPkt ? '0 : len[PW-1:0];
  assign lenZero = (len == '0);
  assign lenFull = (len == LEN_W'(DEPTH));
  assign dataOut = (hold || lenZero) ? 8'h00 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.storeByte) mem[wrIdx] <= inByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      len   <= '0;
      rdPtr <= '0;
    end else if (strobe.startPkt) begin
      len   <= strobe.storeByte ? LEN_W'(1) : '0;
      rdPtr <= '0;
    end else if (strobe.discard) begin
      len <= '0;
    end else if (strobe.storeByte) begin
      len <= len + LEN_W'(1);
    end else if (strobe.popByte) begin
      len   <= len - LEN_W'(1);
      rdPtr <= rdPtr + PW'(1);
    end
  end

  // R6: the count never passes the buffer depth
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    len <= LEN_W'(DEPTH));

  // R4: a pop lowers the count by one
  a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popByte |=> (len == $past(len) - LEN_W'(1)));

  // R5: a read on an empty buffer leaves the count at zero
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && lenZero && !strobe.startPkt) |=> lenZero);

  // R5: an empty buffer shows zero data
  a_r5_empty_data: assert property (@(posedge clk) disable iff (!rstN)
    lenZero |-> (dataOut == 8'h00));
endmodule

// File: rtl/bulkOutRxBuf.sv
module bulkOutRxBuf
  import bulk_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sieValid,
  input  logic [7:0]       sieByte,
  input  logic             sieEnd,
  input  logic             sieGood,
  input  logic             cpuRd,
  input  logic             cpuAck,
  output logic [7:0]       cpuData,
  output logic [LEN_W-1:0] cpuLen,
  output logic             irq
);
  rxStrobe_t  strobe;
  logic       inPkt;
  logic       lenZero;
  logic       lenFull;

  rxCtrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sieValid(sieValid), .sieEnd(sieEnd),
    .sieGood(sieGood), .cpuRd(cpuRd), .cpuAck(cpuAck), .len(cpuLen),
    .lenZero(lenZero), .lenFull(lenFull), .strobe(strobe),
    .inPkt(inPkt), .irq(irq)
  );

  rxData #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(sieByte),
    .hold(inPkt), .cpuRd(cpuRd), .len(cpuLen), .lenZero(lenZero),
    .lenFull(lenFull), .dataOut(cpuData)
  );
endmodule

// File: tb/test_bulkOutRxBuf.sv
module test_bulkOutRxBuf;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int LEN_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sieValid = 1'b0, sieEnd = 1'b0, sieGood = 1'b0, cpuRd = 1'b0, cpuAck = 1'b0;
  logic [7:0] sieByte = 8'h00;
  logic [7:0] cpuData;
  logic [LEN_W-1:0] cpuLen;
  logic irq;

  int checks = 0, failures = 0;
  int expBuf [64];
  int expLen = 0, rdIdx = 0;
  bit expIrq = 1'b0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bulkOutRxBuf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_bulkOutRxBuf (
    .clk(clk), .rstN(rstN), .sieValid(sieValid), .sieByte(sieByte),
    .sieEnd(sieEnd), .sieGood(sieGood), .cpuRd(cpuRd), .cpuAck(cpuAck),
    .cpuData(cpuData), .cpuLen(cpuLen), .irq(irq)
  );

  function automatic int satCount(int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  function automatic bit pktOk(int n, bit good);
    return good && (n <= DEPTH);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendPkt(int n, bit good, bit validAtEnd, bit rdDuring);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sieValid = 1'b1;
      sieByte = 8'($urandom);
      if (i < DEPTH) expBuf[i] = sieByte;
      cpuRd = rdDuring && (i == 1);
      #1;
      if (cpuRd) chk("R9 data during rx", cpuData, 0);
      @(posedge clk); #1;
      chk("R1/R6 live length", cpuLen, satCount(i + 1));
      if (i == 0) begin
        expIrq = 1'b0;
        chk("R7 irq cleared by new packet", irq, 0);
      end
    end
    @(negedge clk);
    cpuRd = 1'b0;
    sieValid = validAtEnd;
    sieByte = 8'hA5;
    sieEnd = 1'b1;
    sieGood = good;
    @(posedge clk); #1;
    expIrq = pktOk(n, good);
    expLen = expIrq ? n : 0;
    rdIdx = 0;
    chk(good ? "R3/R6/R8/R9 length at end" : "R2 length at end", cpuLen, expLen);
    chk(good ? "R3/R6/R8 irq at end" : "R2 irq at end", irq, expIrq);
    @(negedge clk);
    sieValid = 1'b0;
    sieEnd = 1'b0;
  endtask

  task automatic drain(int k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      #1;
      if (expLen > 0) chk("R4 data order", cpuData, expBuf[rdIdx]);
      else chk("R5 empty data", cpuData, 0);
      cpuRd = 1'b1;
      @(posedge clk); #1;
      if (expLen > 0) begin
        expLen--;
        rdIdx++;
        if (expLen == 0) expIrq = 1'b0;
      end
      chk("R4/R5 length after read", cpuLen, expLen);
      chk("R7 irq after read", irq, expIrq);
      @(negedge clk);
      cpuRd = 1'b0;
    end
  endtask

  task automatic ackIrq();
    @(negedge clk);
    cpuAck = 1'b1;
    @(posedge clk); #1;
    expIrq = 1'b0;
    chk("R7 irq after ack", irq, 0);
    chk("R7 length kept on ack", cpuLen, expLen);
    @(negedge clk);
    cpuAck = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset length", cpuLen, 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset data", cpuData, 0);
    rstN = 1'b1;

    sendPkt(5, 1'b1, 1'b1, 1'b1);
    drain(7);
    sendPkt(4, 1'b0, 1'b0, 1'b0);
    drain(1);
    sendPkt(DEPTH, 1'b1, 1'b0, 1'b0);
    drain(3);
    ackIrq();
    sendPkt(DEPTH + 2, 1'b1, 1'b0, 1'b0);
    drain(1);
    sendPkt(0, 1'b1, 1'b1, 1'b0);
    chk("R8 zero length irq held", irq, 1);
    drain(1);
    chk("R8 zero length irq still held", irq, 1);
    ackIrq();
    sendPkt(3, 1'b1, 1'b0, 1'b0);
    drain(1);
    sendPkt(2, 1'b1, 1'b0, 1'b0);
    drain(3);

    for (int p = 0; p < 60; p++) begin
      int n, mode;
      n = $urandom_range(0, DEPTH + 4);
      mode = $urandom_range(0, 2);
      sendPkt(n, ($urandom % 4) != 0, ($urandom % 2) == 1, ($urandom % 3) == 0);
      if (mode == 0) drain(expLen + 2);
      else if (mode == 1) begin
        drain($urandom_range(0, expLen));
        ackIrq();
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule